// File: doc/BRIEF.md
# Timer Prescaler and Clock-Out Divider

This block owns one 8-bit control byte and turns it into two timing products. The first is a one-cycle count-enable pulse that both timers and the watchdog share. It comes from a 4-bit down counter. When the counter reaches zero it emits a pulse and loads the prescale field again, so the pulse spacing can be any value from 1 to 16 system clocks.

The second product is a divided copy of the system clock for an output pin. It is taken from one bit of a free-running counter, so the divide ratio is a power of two from 2 to 16. The clock copy and its pin-driver enable are active only while the enable bit of the control byte is set.

Software writes the byte through a data bus qualified by a write strobe. The byte can be read back at any time. The oscillator choice and the pin multiplexing belong to the blocks around this one.

Top module: `clkctl_top`

## Requirements
- R1: The control byte holds the prescale select in bits 7:4, the clock-out divide select in bits 3:2 and the clock-out enable in bit 0. A strobed write stores these fields, and `rd_data` returns them from the next cycle on.
- R2: After synchronous reset, `rd_data` is 0x00 and `tick_o`, `clk_out_o` and `clk_out_oe_o` are all low.
- R3: With prescale select S, `tick_o` is a single-cycle pulse that repeats every S+1 clocks.
- R4: With prescale select 0000, `tick_o` is high on every clock.
- R5: With prescale select 1011, `tick_o` repeats every 12 clocks.
- R6: A new prescale select takes effect only at the next reload. The spacing already under way completes at the old ratio, and the following spacing uses the new one.
- R7: Divide select 00, 01, 10 and 11 give a `clk_out_o` period of 2, 4, 8 and 16 clocks, with a 50% duty cycle at every setting.
- R8: While the enable bit is 0, `clk_out_o` is held low and `clk_out_oe_o` is low. While it is 1, `clk_out_oe_o` is high.
- R9: Bit 1 of the control byte always reads 0, and writing 1 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte write data |
| rd_data | output | 8 | Control byte read data |
| tick_o | output | 1 | Shared count-enable pulse for the timers and the watchdog |
| clk_out_o | output | 1 | Divided system clock |
| clk_out_oe_o | output | 1 | Enable for the clock-out pin driver |

## Verification
A prescale counter that is loaded at the wrong moment shows up as a wrong tick spacing. This becomes visible within the next period or two, at most 32 clocks. The bench therefore times the intervals between ticks, including the interval that straddles a write of a new prescale value.

A clock-out counter that selects the wrong bit shows up as a wrong number of rising edges in a 32-clock window. A broken duty cycle shows up as a high-time count other than 16 in that window.

A stuck enable or a bad reserved bit is visible at once: on the pin enable, or on the read port one cycle after the write.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int PS_W   = 4;             // prescale field width
  localparam int DS_W   = 2;             // divide-select field width
  localparam int CTRL_W = PS_W + DS_W + 2;

  typedef struct packed {
    logic [PS_W-1:0] psel;
    logic [DS_W-1:0] dsel;
    logic            rsvd;
    logic            en;
  } ctrl_t;
endpackage

// File: rtl/clkctl_reg.sv
module clkctl_reg
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;
  ctrl_t wr_fields;

  always_comb begin
    wr_fields      = ctrl_t'(wr_data);
    wr_fields.rsvd = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_fields;
  end

  assign ctrl_o  = ctrl_q;
  assign rd_data = ctrl_q;

  assert_reset_value_R2: assert property (@(posedge clk)
    rst |=> (rd_data == '0));

  assert_write_store_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[CTRL_W-1:2] == $past(wr_data[CTRL_W-1:2])) && (rd_data[0] == $past(wr_data[0])));

  assert_rsvd_low_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[1]) |=> !rd_data[1]);
endmodule

// File: rtl/clkctl_prescaler.sv
module clkctl_prescaler #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] reload_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         zero;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= zero;
      if (zero) cnt_q <= reload_i;   // new value only picked up here
      else      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));

  assert_no_tick_midperiod_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> !tick_o);
endmodule

// File: rtl/clkctl_clkout.sv
module clkctl_clkout #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clk_out_o,
  output logic             oe_o
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] div_q;
  logic             sel_bit;

  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < CNT_W; i++)
      if (sel_i == SEL_W'(i)) sel_bit = div_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= '0;
      clk_out_o <= 1'b0;
      oe_o      <= 1'b0;
    end else begin
      div_q     <= div_q + 1'b1;
      clk_out_o <= en_i & sel_bit;
      oe_o      <= en_i;
    end
  end

  assert_off_low_R8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!clk_out_o && !oe_o));

  assert_half_rate_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    (en_i && sel_i == '0 && $past(en_i) && $past(sel_i) == '0) |=> (clk_out_o != $past(clk_out_o)));
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              tick_o,
  output logic              clk_out_o,
  output logic              clk_out_oe_o
);
  ctrl_t ctrl;

  clkctl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .ctrl_o  (ctrl)
  );

  clkctl_prescaler #(.W(PS_W)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .reload_i (ctrl.psel),
    .tick_o   (tick_o)
  );

  clkctl_clkout #(.SEL_W(DS_W)) u_cko (
    .clk       (clk),
    .rst       (rst),
    .en_i      (ctrl.en),
    .sel_i     (ctrl.dsel),
    .clk_out_o (clk_out_o),
    .oe_o      (clk_out_oe_o)
  );
endmodule

// File: tb/clkctl_top_tb_top.sv
module clkctl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tick_o, clk_out_o, clk_out_oe_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  clkctl_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick_o(tick_o), .clk_out_o(clk_out_o),
    .clk_out_oe_o(clk_out_oe_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    wr_data = v;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_tick();
    int guard = 0;
    while (!tick_o && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Called while tick_o is high; returns the clocks until the next tick.
  task automatic next_gap(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!tick_o && gap < 100);
  endtask

  task automatic t_reset();
    check("R2 rd_data", rd_data, 0);
    check("R2 tick", tick_o, 0);
    check("R2 clk_out", clk_out_o, 0);
    check("R2 oe", clk_out_oe_o, 0);
  endtask

  task automatic t_every_cycle();
    int g;
    @(negedge clk);
    wait_tick();
    next_gap(g);
    check("R4 gap sel=0", g, 1);
    next_gap(g);
    check("R4 gap sel=0 repeat", g, 1);
  endtask

  task automatic t_ratio(input logic [3:0] s, input string req);
    int g;
    write_ctrl({s, 4'b0000});
    wait_tick();
    next_gap(g);
    next_gap(g);
    check(req, g, int'(s) + 1);
  endtask

  task automatic t_reload_timing();
    int g;
    write_ctrl(8'hF0);
    wait_tick();
    next_gap(g);
    // tick_o is high now; write a short ratio part way through the period
    repeat (3) @(negedge clk);
    write_ctrl(8'h10);
    g = 4;
    while (!tick_o && g < 100) begin
      @(negedge clk);
      g++;
    end
    check("R6 running period kept", g, 16);
    next_gap(g);
    check("R6 new ratio after reload", g, 2);
  endtask

  task automatic t_clkout(input logic [1:0] d);
    int highs = 0;
    int rises = 0;
    logic prev;
    write_ctrl({4'h0, d, 2'b01});
    repeat (4) @(negedge clk);
    check("R8 oe on", clk_out_oe_o, 1);
    prev = clk_out_o;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (clk_out_o) highs++;
      if (clk_out_o && !prev) rises++;
      prev = clk_out_o;
    end
    check("R7 duty", highs, 16);
    check("R7 period", rises, 32 >> (int'(d) + 1));
  endtask

  task automatic t_clkout_off();
    int highs = 0;
    int oes = 0;
    write_ctrl(8'h0C);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (clk_out_o) highs++;
      if (clk_out_oe_o) oes++;
    end
    check("R8 clk_out held low", highs, 0);
    check("R8 oe low", oes, 0);
  endtask

  task automatic t_readback();
    write_ctrl(8'hFF);
    check("R9 bit1 reads 0", rd_data, 8'hFD);
    write_ctrl(8'hA6);
    check("R1 fields stored", rd_data, 8'hA4);
    write_ctrl(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_every_cycle();
    t_ratio(4'hB, "R5 gap sel=1011");
    t_ratio(4'h3, "R3 gap sel=3");
    t_ratio(4'hF, "R3 gap sel=15");
    t_reload_timing();
    for (int d = 0; d < 4; d++) t_clkout(2'(d));
    t_clkout_off();
    t_readback();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule